// File: doc/BRIEF.md
# Asynchronous Processor Bus Cycle Sequencer

This block is the processor-side master of a simple asynchronous memory bus with an 8-bit data path and a 16-bit address. A local requester hands it one read or write at a time. The block then runs a full bus cycle in three timed phases: setup, strobe and hold. It drives the address, the write data with its output enable, the active-low read and write strobes, and four active-low chip selects. The top two address bits choose one of four 16 kB regions: ROM, RAM, serial port and a reserved region.

The three phase lengths are parameters counted in clock cycles, each at least 1. They are chosen to suit the slowest device and apply to every region alike. A strobe is only active while address, data and select are already settled. They stay unchanged for the hold phase after the strobe has been released, so a device never sees a strobe edge together with a changing address.

The request side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle, and a request transfers on a cycle where `req_valid` and `req_ready` are both high. A requester that holds `req_valid` without seeing `req_ready` simply waits; nothing is queued. The response is a single-cycle `rsp_valid` pulse that cannot be stalled, so the requester must take `rsp_rdata` on that cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: `req_ready` is 1 exactly when no bus cycle is in progress; a request transfers on a rising edge with `req_valid` and `req_ready` both 1, and `req_valid` or request fields presented while `req_ready` is 0 have no effect on the running cycle.
- R2: While idle, `rd_n`, `wr_n` and all four `cs_n` bits are 1 and `bus_wdata_oe` is 0.
- R3: For `req_addr[15:14]` = k with k in 0..2, `cs_n[k]` is 0 and the other bits are 1 from the first setup cycle through the last hold cycle (bit 0 ROM, bit 1 RAM, bit 2 serial port); `bus_addr` equals the request address for the whole cycle.
- R4: `cs_n[3]` (reserved region, address bits 15:14 = 3) never goes low; a cycle to that region runs its full timing with all selects at 1.
- R5: In a read, `rd_n` is 0 for exactly STROBE_CYC cycles, beginning SETUP_CYC cycles after the transfer edge, and `wr_n` stays 1; the same timing applies to every region.
- R6: In a write, `bus_wdata` and `bus_wdata_oe` = 1 are driven from the first setup cycle, `wr_n` is 0 for exactly STROBE_CYC cycles after SETUP_CYC setup cycles, `rd_n` stays 1, and address, data and select remain unchanged for HOLD_CYC cycles after `wr_n` returns to 1.
- R7: Read data is taken from `bus_rdata` on the rising edge that ends the last strobe cycle, while `rd_n` is still 0.
- R8: `rsp_valid` is 1 for exactly one cycle, the cycle SETUP_CYC+STROBE_CYC+HOLD_CYC+1 counted from the transfer edge, and for a read `rsp_rdata` holds the captured byte on that cycle.
- R9: An active-low `rst_n` immediately returns the sequencer to idle with every strobe and select deasserted, even mid-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle end-of-cycle pulse |
| rsp_rdata | output | 8 | Captured read byte |
| bus_addr | output | 16 | Address bus |
| bus_wdata | output | 8 | Data to drive onto the bus |
| bus_wdata_oe | output | 1 | Enable for the external data drivers |
| bus_rdata | input | 8 | Data from the bus |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| cs_n | output | 4 | Region selects, active low |

## Verification
Assertions check on every cycle that at most one select is low, that the reserved select stays high, that the two strobes are never low together, and that the idle outputs are quiet. They also check that address, data and select have not moved on the cycle a strobe falls or rises, and that the response is a single pulse. Only the bench scenarios can show the exact phase lengths and the cycle on which read data is taken. They also show which select a given address produces, that a request offered mid-cycle is dropped, and that reset aborts a cycle in progress.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bus_phase_timer.sv
module bus_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/bus_region_decode.sv
module bus_region_decode #(
  parameter int               REGIONS       = 4,
  parameter int               SEL_W         = 2,
  parameter logic [REGIONS-1:0] RESERVED_MASK = 4'b1000
) (
  input  logic               active,
  input  logic [SEL_W-1:0]   region,
  output logic [REGIONS-1:0] cs_n
);

  for (genvar g = 0; g < REGIONS; g++) begin : g_sel
    if (RESERVED_MASK[g]) begin : g_reserved
      assign cs_n[g] = 1'b1;
    end else begin : g_live
      assign cs_n[g] = !(active && (region == SEL_W'(g)));
    end
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int REGIONS    = 4,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  output logic               bus_wdata_oe,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               rd_n,
  output logic               wr_n,
  output logic [REGIONS-1:0] cs_n
);

  localparam int SEL_W   = $clog2(REGIONS);
  localparam int MAX_CYC = max3(SETUP_CYC, STROBE_CYC, HOLD_CYC);
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [REGIONS-1:0] RESV = {1'b1, {(REGIONS-1){1'b0}}};

  phase_e            state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              write_q, rsp_q;
  logic              t_load, t_last;
  logic [CNT_W-1:0]  t_val;
  logic              busy, accept, strobe_end, hold_end;

  assign busy       = (state_q != PH_IDLE);
  assign accept     = req_valid && !busy;
  assign strobe_end = (state_q == PH_STROBE) && t_last;
  assign hold_end   = (state_q == PH_HOLD) && t_last;

  // Phase sequencing: each phase loads the timer with its length minus one
  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      PH_IDLE: if (req_valid) begin
        state_d = PH_SETUP;
        t_load  = 1'b1;
        t_val   = CNT_W'(SETUP_CYC - 1);
      end
      PH_SETUP: if (t_last) begin
        state_d = PH_STROBE;
        t_load  = 1'b1;
        t_val   = CNT_W'(STROBE_CYC - 1);
      end
      PH_STROBE: if (t_last) begin
        state_d = PH_HOLD;
        t_load  = 1'b1;
        t_val   = CNT_W'(HOLD_CYC - 1);
      end
      PH_HOLD: if (t_last) begin
        state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  bus_phase_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .load_val(t_val),
    .last    (t_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_q   <= hold_end;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        write_q <= req_write;
      end
      if (strobe_end && !write_q) begin
        rdata_q <= bus_rdata;
      end
    end
  end

  bus_region_decode #(
    .REGIONS      (REGIONS),
    .SEL_W        (SEL_W),
    .RESERVED_MASK(RESV)
  ) u_decode (
    .active(busy),
    .region(addr_q[ADDR_W-1 -: SEL_W]),
    .cs_n  (cs_n)
  );

  assign req_ready    = !busy;
  assign rd_n         = !((state_q == PH_STROBE) && !write_q);
  assign wr_n         = !((state_q == PH_STROBE) && write_q);
  assign bus_addr     = addr_q;
  assign bus_wdata    = wdata_q;
  assign bus_wdata_oe = busy && write_q;
  assign rsp_valid    = rsp_q;
  assign rsp_rdata    = rdata_q;

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int REGIONS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               bus_wdata_oe,
  input logic               rd_n,
  input logic               wr_n,
  input logic [REGIONS-1:0] cs_n
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rd_n && wr_n && (&cs_n) && !bus_wdata_oe)); // R2

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1); // R3

  AST_RESERVED_SELECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n[REGIONS-1]); // R4

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R5

  AST_RD_FALL_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> ($stable(bus_addr) && $stable(cs_n))); // R5

  AST_WR_FALL_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> ($stable(bus_addr) && $stable(cs_n) && $stable(bus_wdata))); // R6

  AST_WR_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ($stable(bus_addr) && $stable(cs_n) && $stable(bus_wdata)
                     && bus_wdata_oe)); // R6

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8

endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .REGIONS(REGIONS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_wdata_oe(bus_wdata_oe),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .cs_n        (cs_n)
);

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;

  localparam int S   = 2;
  localparam int W   = 3;
  localparam int H   = 2;
  localparam int TOT = S + W + H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wdata_oe;
  logic [7:0]  bus_rdata = 8'hEE;
  logic        rd_n, wr_n;
  logic [3:0]  cs_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int lowcnt = 0;

  always #2 clk = ~clk;

  bus_cycle_seq #(
    .SETUP_CYC(S), .STROBE_CYC(W), .HOLD_CYC(H)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata),
    .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n)
  );

  // Device model: byte changes every strobe cycle so the capture cycle shows
  always @(negedge clk) begin
    if (!rd_n) begin
      lowcnt    <= lowcnt + 1;
      bus_rdata <= bus_addr[7:0] ^ 8'(lowcnt + 1);
    end else begin
      lowcnt    <= 0;
      bus_rdata <= 8'hEE;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
    end
  end

  task automatic check_idle(input string tag);
    check(rd_n && wr_n, {tag, " R2 strobes"}, {rd_n, wr_n}, 3);
    check(cs_n == 4'hF, {tag, " R2 selects"}, cs_n, 4'hF);
    check(!bus_wdata_oe, {tag, " R2 oe"}, bus_wdata_oe, 0);
    check(req_ready, {tag, " R1 ready"}, req_ready, 1);
  endtask

  // Runs one bus cycle and checks every cycle of it against R3..R8
  task automatic run_cycle(input bit wr, input logic [15:0] a, input logic [7:0] d,
                           input bit poke);
    logic [3:0] ecs;
    bit         act, erd, ewr;
    @(negedge clk);
    check(req_ready, "R1 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= TOT + 1; k++) begin
      act = (k <= TOT);
      erd = !(!wr && k > S && k <= S + W);
      ewr = !(wr && k > S && k <= S + W);
      ecs = (act && a[15:14] != 2'd3) ? ~(4'b0001 << a[15:14]) : 4'hF;
      check(rd_n == erd, wr ? "R6 rd_n high in write" : "R5 rd_n timing", rd_n, erd);
      check(wr_n == ewr, wr ? "R6 wr_n timing" : "R5 wr_n high in read", wr_n, ewr);
      check(cs_n == ecs, (a[15:14] == 2'd3) ? "R4 reserved select" : "R3 select",
            cs_n, ecs);
      check(req_ready == !act, "R1 ready during cycle", req_ready, !act);
      if (act) begin
        check(bus_addr == a, "R3 address held", bus_addr, a);
        check(bus_wdata_oe == wr, "R6 data enable", bus_wdata_oe, wr);
        if (wr) check(bus_wdata == d, "R6 data held", bus_wdata, d);
      end
      check(rsp_valid == !act, "R8 response pulse", rsp_valid, !act);
      if (!act && !wr)
        check(rsp_rdata == (a[7:0] ^ 8'(W)), "R7 captured byte", rsp_rdata,
              a[7:0] ^ 8'(W));
      if (poke && k == 2) begin
        req_valid = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = ~d;
      end
      if (poke && k == 4) req_valid = 1'b0;
      @(negedge clk);
    end
    check(!rsp_valid, "R8 pulse ends", rsp_valid, 0);
    check_idle("after cycle");
  endtask

  task automatic t_reset_state();
    check_idle("reset");
    check(!rsp_valid, "R9 no response in reset", rsp_valid, 0);
  endtask

  task automatic t_reads();
    run_cycle(1'b0, 16'h0123, 8'h00, 1'b0);
    run_cycle(1'b0, 16'h5A77, 8'h00, 1'b0);
    run_cycle(1'b0, 16'h800C, 8'h00, 1'b0);
  endtask

  task automatic t_writes();
    run_cycle(1'b1, 16'h1F00, 8'hA5, 1'b0);
    run_cycle(1'b1, 16'h4000, 8'h3C, 1'b0);
    run_cycle(1'b1, 16'hBFFF, 8'hC3, 1'b0);
  endtask

  task automatic t_reserved();
    run_cycle(1'b0, 16'hC010, 8'h00, 1'b0);
    run_cycle(1'b1, 16'hFFFF, 8'h99, 1'b0);
  endtask

  task automatic t_ignored_request();
    run_cycle(1'b0, 16'h6055, 8'h00, 1'b1);
    for (int i = 0; i < 4; i++) begin
      check(rd_n && wr_n, "R1 dropped request did not start", {rd_n, wr_n}, 3);
      @(negedge clk);
    end
  endtask

  task automatic t_back_to_back();
    run_cycle(1'b1, 16'h2222, 8'h11, 1'b0);
    run_cycle(1'b0, 16'h9999, 8'h00, 1'b0);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h4444;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (S) @(negedge clk);
    check(!rd_n, "R5 strobe active before reset", rd_n, 0);
    #1 rst_n = 1'b0;
    #1;
    check(rd_n && wr_n && cs_n == 4'hF, "R9 reset aborts cycle", {rd_n, wr_n, cs_n}, 6'h3F);
    check(req_ready, "R9 idle in reset", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("after reset");
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_reads();
    t_writes();
    t_reserved();
    t_ignored_request();
    t_back_to_back();
    t_mid_reset();
    run_cycle(1'b0, 16'h0001, 8'h00, 1'b0);
    summary();
  end

endmodule